// File: doc/BRIEF.md
# CAN Bit Timing Sampler

This block lays out the quanta of each serial bit for a CAN-style node. A one-cycle quantum enable from an external prescaler is the only thing that moves its schedule. Each bit starts with a one-quantum sync slot. A first phase segment follows, and a second phase segment closes the bit. An 8-bit configuration byte sets the length of both phase segments and chooses between one sample per bit and a three-sample majority vote.

The block gives a pulse at the transmit point and a pulse at the sample point. It also holds the received bit value and reports whether the bus level changed at the sync slot. It raises a configuration error while the stored byte asks for majority sampling with a one-quantum first segment. A byte written in the middle of a bit waits for the bit boundary, so a bit in progress always keeps its own timing.

Top module: `can_bit_timer`

## Requirements
- R1: The configuration byte holds the majority-sampling enable in bit 7, the segment-2 code in bits 6:4 and the segment-1 code in bits 3:0. Segment 1 lasts (code+1) quanta and segment 2 lasts (code+1) quanta. A bit therefore lasts 1 + (seg1 code+1) + (seg2 code+1) quanta.
- R2: The schedule advances only on a cycle with `tq_en` high. `tx_point` and `sample_point` go high only in the cycle that follows a `tq_en` cycle.
- R3: `tx_point` is a one-cycle pulse in the cycle after the quantum tick of the sync slot, which is the first quantum of every bit.
- R4: `sample_point` is a one-cycle pulse in the cycle after the tick of the last segment-1 quantum. That tick is quantum index (seg1 code+1) of the bit, counting the sync slot as index 0.
- R5: With bit 7 clear, `rx_bit` takes the `rx_in` value seen at the sample tick. It updates together with `sample_point` and holds its value otherwise.
- R6: With bit 7 set, `rx_bit` takes the majority of the `rx_in` values seen at the sample tick and at the two quantum ticks just before it.
- R7: A byte written with `cfg_wr` before the last quantum tick of a bit does not change the current bit. It governs the bit that follows.
- R8: In the cycle after each sync tick, `sync_edge` becomes 1 if `rx_in` at that tick differs from `rx_in` at the previous quantum tick, and 0 otherwise. It holds its value until the next sync tick.
- R9: `cfg_err` is high from the cycle after a write whenever the stored byte has bit 7 set and bits 3:0 equal to zero.
- R10: After reset the stored and active bytes are zero, which gives 3-quantum bits with single sampling that start at the sync slot. `tx_point`, `sample_point`, `sync_edge` and `cfg_err` are 0, `rx_bit` is 1, and the tick history reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tq_en | input | 1 | One-cycle time-quantum tick |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_data | input | 8 | Configuration byte {triple, seg2 code, seg1 code} |
| rx_in | input | 1 | Bus level |
| tx_point | output | 1 | Transmit-point pulse |
| sample_point | output | 1 | Sample-point pulse |
| rx_bit | output | 1 | Received bit value |
| sync_edge | output | 1 | Bus level changed at the last sync slot |
| cfg_err | output | 1 | Stored byte breaks the majority-mode length rule |

## Verification
A wrong segment counter shows up within one bit time: `sample_point` or `tx_point` appears at the wrong quantum index, and every later bit keeps the same shift. A wrong active configuration shows up in the first bit after a write, either as a sample point that moves in the bit still under the old byte or as one that fails to move in the next bit. A corrupted sample history shows up only at the next sample point, where `rx_bit` takes a value that differs from the majority of the three ticks. The bench therefore drives those three ticks with values that disagree.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    localparam int TS1_W = 4;
    localparam int TS2_W = 3;
    localparam int CFG_W = 1 + TS2_W + TS1_W;
    localparam int CNT_W = (TS1_W > TS2_W) ? TS1_W : TS2_W;

    typedef struct packed {
        logic             triple;
        logic [TS2_W-1:0] ts2;
        logic [TS1_W-1:0] ts1;
    } cfg_t;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_TS1  = 2'd1,
        PH_TS2  = 2'd2
    } phase_e;

    typedef struct packed {
        logic at_sync;
        logic at_samp;
        logic at_end;
    } tick_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic cfg_bad(input cfg_t c);
        return c.triple && (c.ts1 == '0);
    endfunction

endpackage

// File: rtl/cbt_cfg_reg.sv
module cbt_cfg_reg
    import cbt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  cfg_t wr_data,
    input  logic load_act,
    output cfg_t act_cfg,
    output logic cfg_err
);
    cfg_t stored_q;
    cfg_t act_q;

    // Stored byte follows the write strobe at any time.
    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= '0;
        end else if (wr_en) begin
            stored_q <= wr_data;
        end
    end

    // Active byte is copied only at the bit boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else if (load_act) begin
            act_q <= stored_q;
        end
    end

    assign act_cfg = act_q;
    assign cfg_err = cfg_bad(stored_q);

endmodule

// File: rtl/cbt_seg_ctr.sv
module cbt_seg_ctr
    import cbt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  cfg_t  act_cfg,
    output tick_t ev
);
    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_ts1;
    logic             last_ts2;

    assign last_ts1 = (cnt_q == CNT_W'(act_cfg.ts1));
    assign last_ts2 = (cnt_q == CNT_W'(act_cfg.ts2));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_SYNC;
            cnt_q   <= '0;
        end else if (tick) begin
            unique case (phase_q)
                PH_SYNC: begin
                    phase_q <= PH_TS1;
                    cnt_q   <= '0;
                end
                PH_TS1: begin
                    if (last_ts1) begin
                        phase_q <= PH_TS2;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_TS2: begin
                    if (last_ts2) begin
                        phase_q <= PH_SYNC;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_SYNC;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        ev.at_sync = tick && (phase_q == PH_SYNC);
        ev.at_samp = tick && (phase_q == PH_TS1) && last_ts1;
        ev.at_end  = tick && (phase_q == PH_TS2) && last_ts2;
    end

endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler
    import cbt_pkg::*;
#(
    parameter int HIST = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic at_sync,
    input  logic at_samp,
    input  logic triple,
    input  logic rx_in,
    output logic rx_bit,
    output logic sync_edge
);
    logic [HIST-1:0] hist_q;   // hist_q[0] is the most recent tick sample
    logic            rx_bit_q;
    logic            edge_q;
    logic            vote;

    assign vote = maj3(hist_q[1], hist_q[0], rx_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '1;
        end else if (tick) begin
            hist_q <= {hist_q[HIST-2:0], rx_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_bit_q <= 1'b1;
        end else if (at_samp) begin
            rx_bit_q <= triple ? vote : rx_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= 1'b0;
        end else if (at_sync) begin
            edge_q <= (rx_in != hist_q[0]);
        end
    end

    assign rx_bit    = rx_bit_q;
    assign sync_edge = edge_q;

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import cbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tq_en,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             rx_in,
    output logic             tx_point,
    output logic             sample_point,
    output logic             rx_bit,
    output logic             sync_edge,
    output logic             cfg_err
);
    cfg_t  act_cfg;
    tick_t ev;
    logic  tx_q;
    logic  smp_q;

    cbt_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr),
        .wr_data  (cfg_t'(cfg_data)),
        .load_act (ev.at_end),
        .act_cfg  (act_cfg),
        .cfg_err  (cfg_err)
    );

    cbt_seg_ctr u_seg (
        .clk     (clk),
        .rst     (rst),
        .tick    (tq_en),
        .act_cfg (act_cfg),
        .ev      (ev)
    );

    cbt_sampler #(.HIST(2)) u_smp (
        .clk       (clk),
        .rst       (rst),
        .tick      (tq_en),
        .at_sync   (ev.at_sync),
        .at_samp   (ev.at_samp),
        .triple    (act_cfg.triple),
        .rx_in     (rx_in),
        .rx_bit    (rx_bit),
        .sync_edge (sync_edge)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= 1'b0;
            smp_q <= 1'b0;
        end else begin
            tx_q  <= ev.at_sync;
            smp_q <= ev.at_samp;
        end
    end

    assign tx_point     = tx_q;
    assign sample_point = smp_q;

endmodule

// File: rtl/cbt_checker.sv
module cbt_checker (
    input logic       clk,
    input logic       rst,
    input logic       tq_en,
    input logic       cfg_wr,
    input logic [7:0] cfg_data,
    input logic       rx_in,
    input logic       tx_point,
    input logic       sample_point,
    input logic       rx_bit,
    input logic       sync_edge,
    input logic       cfg_err,
    input logic       act_triple
);
    AST_TX_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        tx_point |-> $past(tq_en)); // R2

    AST_SAMP_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        sample_point |-> $past(tq_en)); // R2

    AST_TX_SAMP_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        !(tx_point && sample_point)); // R3

    AST_RXBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sample_point |-> rx_bit == $past(rx_bit)); // R5

    AST_SINGLE_VALUE: assert property (@(posedge clk) disable iff (rst)
        (sample_point && !$past(act_triple)) |-> rx_bit == $past(rx_in)); // R5

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tx_point |-> sync_edge == $past(sync_edge)); // R8

    AST_CFG_ERR_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_wr) && !$past(rst)) |->
            cfg_err == ($past(cfg_data[7]) && ($past(cfg_data[3:0]) == 4'd0))); // R9
endmodule

bind can_bit_timer cbt_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .tq_en        (tq_en),
    .cfg_wr       (cfg_wr),
    .cfg_data     (cfg_data),
    .rx_in        (rx_in),
    .tx_point     (tx_point),
    .sample_point (sample_point),
    .rx_bit       (rx_bit),
    .sync_edge    (sync_edge),
    .cfg_err      (cfg_err),
    .act_triple   (act_cfg.triple)
);

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tq_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic       rx_in = 1'b1;
    logic       tx_point, sample_point, rx_bit, sync_edge, cfg_err;

    int checks = 0;
    int errors = 0;
    logic [7:0] cur_cfg = 8'h00;
    logic [7:0] pend_cfg = 8'h00;
    logic       last_rx = 1'b1;

    always #5 clk = ~clk;

    can_bit_timer u_dut (
        .clk(clk), .rst(rst), .tq_en(tq_en), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .rx_in(rx_in), .tx_point(tx_point), .sample_point(sample_point),
        .rx_bit(rx_bit), .sync_edge(sync_edge), .cfg_err(cfg_err)
    );

    // Vector: [15:8] cfg, [7] fill, [6] pre2, [5] pre1, [4] smp, [3] expected rx_bit
    localparam logic [15:0] VEC [8] = '{
        {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'b0},  // R5 shortest bit
        {8'h23, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'b0},  // R5
        {8'h83, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'b0},  // R6 vote 1,1,0
        {8'h83, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b0},  // R6 vote 0,1,0
        {8'hFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'b0},  // R6 longest bit
        {8'h7F, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'b0},  // R5 single ignores neighbours
        {8'h81, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'b0},  // R6 pre2 falls on sync
        {8'h81, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b0}   // R6
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_data = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        pend_cfg = d;
        chk(cfg_err == (d[7] && d[3:0] == 4'd0), "R9 cfg_err", int'(cfg_err),
            int'(d[7] && d[3:0] == 4'd0));
    endtask

    task automatic run_bit(input logic fill, input logic pre2, input logic pre1,
                           input logic smp, input logic exp_bit, input string tag);
        int t1 = int'(cur_cfg[3:0]) + 1;
        int t2 = int'(cur_cfg[6:4]) + 1;
        int n  = 1 + t1 + t2;
        int s  = t1;
        for (int p = 0; p < n; p++) begin
            logic v;
            v = fill;
            if (p == s - 2) v = pre2;
            if (p == s - 1) v = pre1;
            if (p == s)     v = smp;
            @(negedge clk);
            tq_en = 1'b1;
            rx_in = v;
            @(negedge clk);
            tq_en = 1'b0;
            chk(tx_point == (p == 0), "R3 tx_point", int'(tx_point), int'(p == 0));
            chk(sample_point == (p == s), "R4/R1/R7 sample_point", int'(sample_point), int'(p == s));
            if (p == 0)
                chk(sync_edge == (v != last_rx), "R8 sync_edge", int'(sync_edge), int'(v != last_rx));
            if (p == s)
                chk(rx_bit == exp_bit, tag, int'(rx_bit), int'(exp_bit));
            last_rx = v;
        end
        cur_cfg = pend_cfg;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(tx_point == 1'b0, "R10 tx_point", int'(tx_point), 0);
        chk(sample_point == 1'b0, "R10 sample_point", int'(sample_point), 0);
        chk(rx_bit == 1'b1, "R10 rx_bit", int'(rx_bit), 1);
        chk(sync_edge == 1'b0, "R10 sync_edge", int'(sync_edge), 0);
        chk(cfg_err == 1'b0, "R10 cfg_err", int'(cfg_err), 0);
        // R10 first bits at 3 quanta with a bus edge at sync
        run_bit(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R10 rx_bit");
        run_bit(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 rx_bit");

        // R2 idle cycles without tq_en leave outputs quiet
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!tx_point && !sample_point, "R2 idle pulses", int'(tx_point | sample_point), 0);
        end

        // Vector table: R1 R5 R6 R7
        for (int k = 0; k < 8; k++) begin
            logic [15:0] v;
            v = VEC[k];
            write_cfg(v[15:8]);
            run_bit(v[7], v[7], v[7], v[7], v[7], "R7 rx_bit old cfg bit");
            run_bit(v[7], v[6], v[5], v[4], v[3], v[15] ? "R6 rx_bit" : "R5 rx_bit");
        end

        // R9 error rule corner cases
        write_cfg(8'h80);
        write_cfg(8'h81);
        write_cfg(8'h70);
        write_cfg(8'h80);
        write_cfg(8'h00);
        run_bit(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R7 rx_bit");
        run_bit(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5 rx_bit");

        // R7 two writes before a boundary: last one wins
        write_cfg(8'h12);
        write_cfg(8'h05);
        run_bit(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R7 rx_bit");
        run_bit(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 rx_bit");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule